// File: doc/BRIEF.md
# Two-Level Prioritised Interrupt Controller

This block gathers fifteen interrupt sources, numbered 1 to 15, and presents one interrupt number to a single processor. Each source is synchronised, and a rising edge sets a shared pending bit. If the source is marked for broadcast, the edge instead sets a forced-request bit in every processor's force register. Software can also force requests directly and can withdraw them.

For processor 0, the pending bits and that processor's forced bits are combined and then gated by its mask. A level register divides the sources into a high group and a low group. The output is the highest-numbered active source in the high group. If the high group has no active source, the output is the highest-numbered active source in the low group. The processor, or software through a clear register, retires serviced sources.

Registers are reached through a simple 32-bit word bus in a 256-byte window. Force and mask registers exist for up to `NCPU` processors. Only processor 0 drives the output.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, every readable word in the window reads zero and `irq_num` is 0.
- R2: Bit 0 is never stored. Writes to level (0x00), force alias (0x08), broadcast (0x14), mask (0x40 + 4·p) and force (0x80 + 4·p) read back with bit 0 cleared. Bits [31:16] of those registers read zero.
- R3: A rising edge on `irq_req[n]` (n = 1..15) whose broadcast bit is clear sets pending bit n (read at 0x04). An input held high sets the bit only once: after it is cleared, the bit stays clear while the input stays high.
- R4: A rising edge on a source whose broadcast bit is set sets bit n in the force register of every processor and leaves the pending register untouched.
- R5: The active set is (pending | force0) & mask0. `irq_num` is the highest-numbered active source whose level bit is 1. If no such source exists, it is the highest-numbered active source overall. It is 0 when nothing is active.
- R6: Writing a value to the clear register (0x0C) clears those bits in both pending and force0. An `ack_valid` strobe with `ack_num` = n clears bit n in both registers.
- R7: A write to force register p (0x80 + 4·p) ORs in data bits [15:1] and then clears the bits named in data bits [31:17]. A bit named in both fields ends up cleared.
- R8: A write to 0x08 replaces force0 with data bits [15:1].
- R9: Writes to pending (0x04) and status (0x10) have no effect. Clear, status and all unmapped offsets (0x18–0x3C, 0xC0–0xFC) read zero, and writes to them change nothing.
- R10: If an acknowledge of source n lands in the same cycle as a new rising edge on source n, the pending bit ends up set.
- R11: `irq_num` reflects a register write one clock after the edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_req | input | 16 | Raw interrupt inputs; bit 0 ignored |
| ack_valid | input | 1 | One-cycle acknowledge strobe |
| ack_num | input | 4 | Number of the serviced source |
| irq_num | output | 4 | Selected interrupt number, 0 = none |

## Verification
Directed patterns place active sources in both groups at once, so that a wrong choice between the high and low groups shows up in `irq_num`. Dropping the level bits then checks the fall-back to the low group. Set and clear fields that overlap in a force write separate clear-after-set ordering from the reverse. Broadcast edges are checked against both the pending register and the last processor's force register, which shows where the edge was routed. An acknowledge timed into the same cycle as a fresh edge tells which of the two wins. Random register writes, edges and acknowledges, checked against a bench model of every register, cover mixtures the directed cases miss.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NCPU = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [15:0] irq_req,
  input  logic        ack_valid,
  input  logic [3:0]  ack_num,
  output logic [3:0]  irq_num
);
  localparam int NSRC = 16;
  localparam logic [NSRC-1:0] VMASK = {{(NSRC-1){1'b1}}, 1'b0};

  logic [NSRC-1:0] lvl_q, pend_q, bcast_q;
  logic [NSRC-1:0] mask_q  [NCPU];
  logic [NSRC-1:0] force_q [NCPU];
  logic [NSRC-1:0] force_d [NCPU];
  logic [NSRC-1:0] s1, s2, s3;

  wire [5:0] widx    = bus_addr[7:2];
  wire [3:0] cpu_sel = widx[3:0];
  wire       wr      = bus_en & bus_we;
  wire       wr_lvl  = wr && widx == 6'd0;
  wire       wr_alias= wr && widx == 6'd2;
  wire       wr_clr  = wr && widx == 6'd3;
  wire       wr_bc   = wr && widx == 6'd5;
  wire       wr_mask = wr && widx[5:4] == 2'b01;
  wire       wr_frc  = wr && widx[5:4] == 2'b10;

  wire [NSRC-1:0] wlo    = bus_wdata[NSRC-1:0] & VMASK;
  wire [NSRC-1:0] whi    = bus_wdata[31:16] & VMASK;
  wire [NSRC-1:0] rise_v = s2 & ~s3 & VMASK;
  wire [NSRC-1:0] ack_v  = ack_valid ? ((NSRC'(1) << ack_num) & VMASK) : '0;
  wire [NSRC-1:0] clr_v  = (wr_clr ? wlo : '0) | ack_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      lvl_q <= '0; pend_q <= '0; bcast_q <= '0;
    end else begin
      s1 <= irq_req; s2 <= s1; s3 <= s2;
      if (wr_lvl) lvl_q <= wlo;
      if (wr_bc)  bcast_q <= wlo;
      pend_q <= (pend_q & ~clr_v) | (rise_v & ~bcast_q);
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    always_comb begin
      force_d[c] = force_q[c];
      if (wr_frc && cpu_sel == 4'(c)) force_d[c] = (force_d[c] | wlo) & ~whi;
      if (c == 0) begin
        if (wr_alias) force_d[c] = wlo;
        force_d[c] = force_d[c] & ~clr_v;
      end
      force_d[c] = force_d[c] | (rise_v & bcast_q);
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        force_q[c] <= '0;
        mask_q[c]  <= '0;
      end else begin
        force_q[c] <= force_d[c];
        if (wr_mask && cpu_sel == 4'(c)) mask_q[c] <= wlo;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (widx)
      6'd0: bus_rdata[NSRC-1:0] = lvl_q;
      6'd1: bus_rdata[NSRC-1:0] = pend_q;
      6'd2: bus_rdata[NSRC-1:0] = force_q[0];
      6'd5: bus_rdata[NSRC-1:0] = bcast_q;
      default: begin
        if (int'(cpu_sel) < NCPU) begin
          if (widx[5:4] == 2'b01) bus_rdata[NSRC-1:0] = mask_q[cpu_sel];
          if (widx[5:4] == 2'b10) bus_rdata[NSRC-1:0] = force_q[cpu_sel];
        end
      end
    endcase
  end

  function automatic logic [3:0] top_bit(input logic [NSRC-1:0] v);
    top_bit = '0;
    for (int i = 1; i < NSRC; i++) if (v[i]) top_bit = 4'(i);
  endfunction

  wire [NSRC-1:0] eff_v  = (pend_q | force_q[0]) & mask_q[0];
  wire [NSRC-1:0] hi_v   = eff_v & lvl_q;
  wire [NSRC-1:0] pick_v = (|hi_v) ? hi_v : eff_v;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_num <= '0;
    else        irq_num <= top_bit(pick_v);
  end

  assert_bit0_unused_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q[0] && !lvl_q[0] && !force_q[0][0] && !mask_q[0][0]);

  assert_edge_to_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rise_v & ~bcast_q) & ~pend_q) == '0);

  assert_bcast_reaches_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(rise_v & bcast_q) & ~force_q[0]) == '0) &&
    (($past(rise_v & bcast_q) & ~force_q[NCPU-1]) == '0));

  assert_num_is_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_num != 4'd0 |-> (($past(eff_v) >> irq_num) & NSRC'(1)) != '0);

  assert_high_group_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_num != 4'd0 && $past(|(eff_v & lvl_q))) |-> (($past(lvl_q) >> irq_num) & NSRC'(1)) != '0);

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_num != 4'd0 && !rise_v[ack_num])
      |=> !pend_q[$past(ack_num)] && !force_q[0][$past(ack_num)]);

  assert_pend_ignores_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~$past(pend_q)) == ($past(rise_v & ~bcast_q) & ~$past(pend_q)));
endmodule

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [15:0] irq_req = '0;
  logic ack_valid = 1'b0;
  logic [3:0] ack_num = '0, irq_num;
  int errors = 0, checks = 0;

  logic [15:0] m_lvl, m_pend, m_bc;
  logic [15:0] m_mask [16];
  logic [15:0] m_frc  [16];

  always #2.5 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (.clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_wdata,
    .bus_rdata, .irq_req, .ack_valid, .ack_num, .irq_num);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_num();
    logic [15:0] e = (m_pend | m_frc[0]) & m_mask[0];
    logic [15:0] p = ((e & m_lvl) != 0) ? (e & m_lvl) : e;
    exp_num = 0;
    for (int i = 1; i < 16; i++) if (p[i]) exp_num = 4'(i);
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    int w = a >> 2;
    if (w == 0) return {16'h0, m_lvl};
    if (w == 1) return {16'h0, m_pend};
    if (w == 2) return {16'h0, m_frc[0]};
    if (w == 5) return {16'h0, m_bc};
    if (w >= 16 && w < 32) return {16'h0, m_mask[w-16]};
    if (w >= 32 && w < 48) return {16'h0, m_frc[w-32]};
    return 0;
  endfunction

  function automatic void model_wr(logic [7:0] a, logic [31:0] d);
    int w = a >> 2;
    logic [15:0] lo = d[15:0] & 16'hFFFE, hi = d[31:16] & 16'hFFFE;
    if (w == 0) m_lvl = lo;
    else if (w == 2) m_frc[0] = lo;
    else if (w == 3) begin m_pend &= ~lo; m_frc[0] &= ~lo; end
    else if (w == 5) m_bc = lo;
    else if (w >= 16 && w < 32) m_mask[w-16] = lo;
    else if (w >= 32 && w < 48) m_frc[w-32] = (m_frc[w-32] | lo) & ~hi;
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk); bus_en = 0; bus_we = 0;
    model_wr(a, d);
  endtask

  task automatic rd_check(string req, logic [7:0] a);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a; #1;
    check(req, bus_rdata, exp_rd(a));
    bus_en = 0;
  endtask

  task automatic pulse(logic [15:0] v);
    @(negedge clk); irq_req = v;
    repeat (4) @(posedge clk);
    for (int i = 1; i < 16; i++) if (v[i]) begin
      if (m_bc[i]) for (int c = 0; c < 16; c++) m_frc[c][i] = 1'b1;
      else m_pend[i] = 1'b1;
    end
    @(negedge clk); irq_req = 0;
    repeat (4) @(posedge clk);
  endtask

  task automatic ack(logic [3:0] n);
    @(negedge clk); ack_valid = 1; ack_num = n;
    @(posedge clk); @(negedge clk); ack_valid = 0;
    if (n != 0) begin m_pend[n] = 1'b0; m_frc[0][n] = 1'b0; end
  endtask

  task automatic settle_num(string req);
    repeat (2) @(posedge clk); @(negedge clk);
    check(req, {28'h0, irq_num}, {28'h0, exp_num()});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] old;
    void'($urandom(32'd7321));
    m_lvl = 0; m_pend = 0; m_bc = 0;
    for (int c = 0; c < 16; c++) begin m_mask[c] = 0; m_frc[c] = 0; end
    repeat (4) @(posedge clk); @(negedge clk); rst_n = 1;

    for (int w = 0; w < 64; w++) rd_check("R1 reset read", 8'(w * 4));
    check("R1 reset irq_num", {28'h0, irq_num}, 0);

    wr(8'h00, 32'hFFFF_FFFF); rd_check("R2 level bit0", 8'h00);
    wr(8'h44, 32'hFFFF_FFFF); rd_check("R2 mask bit0", 8'h44);
    wr(8'h14, 32'h0000_0001); rd_check("R2 bcast bit0", 8'h14);
    wr(8'h00, 0);

    wr(8'h04, 32'hFFFF); rd_check("R9 pending ignores write", 8'h04);
    wr(8'h10, 32'hFFFF); rd_check("R9 status reads zero", 8'h10);
    wr(8'hC0, 32'hF); rd_check("R9 unmapped reads zero", 8'hC0);
    rd_check("R9 clear reads zero", 8'h0C);
    rd_check("R9 unmapped gap", 8'h20);

    wr(8'h40, 32'hFFFF);
    @(negedge clk); irq_req = 16'h0008;
    repeat (8) @(posedge clk); m_pend[3] = 1; @(negedge clk);
    rd_check("R3 edge sets pending", 8'h04);
    wr(8'h0C, 32'h0008);
    repeat (6) @(posedge clk);
    rd_check("R3 held input sets once", 8'h04);
    @(negedge clk); irq_req = 0; repeat (4) @(posedge clk);

    wr(8'h00, 32'h0010);
    pulse(16'h0218);
    settle_num("R5 high group wins");
    check("R5 high group value", {28'h0, irq_num}, 4);
    old = irq_num;
    wr(8'h00, 0);
    check("R11 old value before update", {28'h0, irq_num}, {28'h0, old});
    @(posedge clk); @(negedge clk);
    check("R11 new value one clock later", {28'h0, irq_num}, 9);
    wr(8'h40, 32'h0010); settle_num("R5 mask gates");
    wr(8'h0C, 32'hFFFF); settle_num("R6 clear write empties");
    check("R5 nothing active", {28'h0, irq_num}, 0);
    wr(8'h40, 32'hFFFF);

    wr(8'h80, 32'h0004_0006); rd_check("R7 clear wins over set", 8'h80);
    wr(8'hBC, 32'h0000_1100); rd_check("R7 force last cpu", 8'hBC);
    wr(8'hBC, 32'h0100_0000); rd_check("R7 clear field", 8'hBC);
    wr(8'h08, 32'h0000_00A1); rd_check("R8 alias replaces", 8'h08);
    settle_num("R5 forced request");

    wr(8'h14, 32'h0020); pulse(16'h0020);
    rd_check("R4 pending untouched", 8'h04);
    rd_check("R4 force0 set", 8'h80);
    rd_check("R4 force15 set", 8'hBC);

    pulse(16'h0400);
    ack(4'd10); rd_check("R6 ack clears pending", 8'h04);
    ack(4'd5);  rd_check("R6 ack clears force0", 8'h08);

    @(negedge clk); irq_req = 16'h0040;
    @(posedge clk); @(posedge clk);
    @(negedge clk); ack_valid = 1; ack_num = 4'd6;
    @(posedge clk); @(negedge clk); ack_valid = 0; m_pend[6] = 1;
    rd_check("R10 new request wins over ack", 8'h04);
    @(negedge clk); irq_req = 0; repeat (4) @(posedge clk);

    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 5;
      if (op < 2) begin
        int r = $urandom % 9;
        logic [7:0] a;
        if (r < 6) a = 8'(r * 4);
        else if (r == 6) a = 8'(8'h40 + 4 * ($urandom % 16));
        else if (r == 7) a = 8'(8'h80 + 4 * ($urandom % 16));
        else a = 8'(4 * ($urandom % 64));
        wr(a, $urandom);
      end else if (op == 2) pulse(16'($urandom));
      else if (op == 3) ack(4'($urandom));
      else rd_check("R9 random read", 8'(4 * ($urandom % 64)));
      settle_num("R5 random irq_num");
    end
    for (int w = 0; w < 64; w++) rd_check("R7 final register sweep", 8'(w * 4));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule